// File: doc/BRIEF.md
# Two-Level Rotating Bus Arbiter

This block decides which of up to `N_REQ` bus masters owns a shared downstream bus. One of those masters is the bridge that hosts the arbiter (its index is a parameter). Each master sits in one of two groups, set by one bit per master in a group mask. The high group takes turns in a round-robin. The low group as a whole fills one extra place in that round-robin, and inside the low group a second round-robin picks which member is served.

Requests and grants are active-low. The arbiter works out a new grant on every clock. Both rotations move only when a transaction actually starts, meaning the bus is idle while the granted master is still requesting. The master that started becomes the last choice in its own group. When nobody requests, the grant parks on the bridge's own index. A strap input turns the arbiter off, so that an external arbiter can take over; while it is off, no grant is driven.

Top module: `rr2_bus_arbiter`

## Requirements
- R1: While enabled and at least one request is active, the single active grant goes to a master whose request was active at the previous clock edge.
- R2: Bit i of `lo_mask` = 1 puts master i in the low group, and 0 puts it in the high group. A low-group master is granted only when the rotation reaches the group's shared place and no high master ahead of that place is requesting.
- R3: The high rotation has `N_REQ`+1 places. Place i (i < `N_REQ`) is master i, and place `N_REQ` is the low group. When a high master i starts a transaction, search next begins at place i+1. When a low master starts, search next begins at place 0.
- R4: At most one bit of `gnt_n` is low in any cycle.
- R5: The low rotation has `N_REQ` places. It advances only when a low master j starts; search in the low group then begins at j+1 modulo `N_REQ`.
- R6: When `arb_off` = 1 at a clock edge, all of `gnt_n` is high after that edge, and no rotation moves while the arbiter is off.
- R7: While enabled with no active request, the grant after the edge is on master `HOME_IDX`.
- R8: If the low group's place comes up while no low master requests, that place is skipped in the same decision and the next requesting high master is granted.
- R9: A start is `bus_idle` = 1 while the currently granted master's request is active. The grant after that edge already reflects the moved rotation.
- R10: During reset and right after it, all grants are inactive. Both rotations begin at place 0.
- R11: With `N_REQ`=4, `lo_mask`=4'b1100, all requests held active and a start on every edge, the grants after reset are 0,1,2,0,1,3,0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| arb_off | input | 1 | Strap: 1 disables the arbiter |
| bus_idle | input | 1 | Bus idle; with an active granted request it marks a transaction start |
| req_n | input | N_REQ | Active-low requests, one per master |
| lo_mask | input | N_REQ | Group mask, 1 = low group |
| gnt_n | output | N_REQ | Active-low registered one-hot grants |

## Verification
Every grant is registered, so it is due exactly one clock edge after the requests, mask, enable and bus-idle values that produce it. A start at an edge already shapes the grant loaded at that same edge. The bench changes inputs at the falling edge, works out the expected grant from the requirement rules for that next rising edge, and reads `gnt_n` at the falling edge that follows. That keeps each comparison exactly one register away from its stimulus. A near-exhaustive sweep over every mask and request pattern of a four-master instance, with alternating start conditions, adds to the directed rotation sequences.

// File: rtl/rr2_pkg.sv
package rr2_pkg;
  // add b to a modulo w, assuming a < w and b <= w
  function automatic int unsigned wrap_add(int unsigned a, int unsigned b, int unsigned w);
    int unsigned s;
    s = a + b;
    if (s >= w) s = s - w;
    return s;
  endfunction
endpackage

// File: rtl/rr2_pick.sv
module rr2_pick #(
  parameter int W  = 5,
  localparam int PW = $clog2(W)
) (
  input  logic [W-1:0]  elig,
  input  logic [PW-1:0] base,
  output logic [W-1:0]  win_oh,
  output logic          found
);
  import rr2_pkg::*;

  always_comb begin
    int unsigned idx;
    win_oh = '0;
    found  = 1'b0;
    for (int k = 0; k < W; k++) begin
      idx = wrap_add(32'(base), 32'(k), 32'(W));
      if (!found && elig[idx]) begin
        win_oh[idx] = 1'b1;
        found       = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rr2_ptrs.sv
module rr2_ptrs #(
  parameter int N_REQ = 8,
  localparam int SLOTS = N_REQ + 1,
  localparam int HW = $clog2(SLOTS),
  localparam int LW = $clog2(N_REQ)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [LW-1:0] gidx,
  input  logic          g_low,
  output logic [HW-1:0] hi_nxt,
  output logic [LW-1:0] lo_nxt
);
  import rr2_pkg::*;

  logic [HW-1:0] hi_q;
  logic [LW-1:0] lo_q;

  always_comb begin
    hi_nxt = hi_q;
    lo_nxt = lo_q;
    if (start) begin
      if (g_low) begin
        hi_nxt = '0;
        lo_nxt = LW'(wrap_add(32'(gidx), 32'd1, 32'(N_REQ)));
      end else begin
        hi_nxt = HW'(32'(gidx) + 32'd1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      hi_q <= hi_nxt;
      lo_q <= lo_nxt;
    end
  end
endmodule

// File: rtl/rr2_bus_arbiter.sv
module rr2_bus_arbiter #(
  parameter int N_REQ    = 8,
  parameter int HOME_IDX = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arb_off,
  input  logic             bus_idle,
  input  logic [N_REQ-1:0] req_n,
  input  logic [N_REQ-1:0] lo_mask,
  output logic [N_REQ-1:0] gnt_n
);
  localparam int SLOTS = N_REQ + 1;
  localparam int HW    = $clog2(SLOTS);
  localparam int LW    = $clog2(N_REQ);

  logic [N_REQ-1:0] req, gnt_q, gnt_d, win_oh, lo_oh, hi_req, lo_req;
  logic [SLOTS-1:0] hi_elig, hi_oh;
  logic [HW-1:0]    hi_nxt;
  logic [LW-1:0]    lo_nxt, gidx;
  logic             start, hi_found, lo_found;

  assign req    = ~req_n;
  assign hi_req = req & ~lo_mask;
  assign lo_req = req & lo_mask;
  assign start  = bus_idle && |(gnt_q & req);

  always_comb begin
    gidx = '0;
    for (int i = 0; i < N_REQ; i++)
      if (gnt_q[i]) gidx = LW'(i);
  end

  rr2_ptrs #(.N_REQ(N_REQ)) ptrs_i (
    .clk(clk), .rst(rst), .start(start), .gidx(gidx),
    .g_low(lo_mask[gidx]), .hi_nxt(hi_nxt), .lo_nxt(lo_nxt)
  );

  assign hi_elig = {|lo_req, hi_req};

  rr2_pick #(.W(SLOTS)) hi_pick_i (
    .elig(hi_elig), .base(hi_nxt), .win_oh(hi_oh), .found(hi_found)
  );

  rr2_pick #(.W(N_REQ)) lo_pick_i (
    .elig(lo_req), .base(lo_nxt), .win_oh(lo_oh), .found(lo_found)
  );

  assign win_oh = hi_oh[N_REQ] ? lo_oh : hi_oh[N_REQ-1:0];

  always_comb begin
    if (arb_off)
      gnt_d = '0;
    else if (hi_found || lo_found)
      gnt_d = win_oh;
    else
      gnt_d = N_REQ'(1) << HOME_IDX;
  end

  always_ff @(posedge clk) begin
    if (rst) gnt_q <= '0;
    else     gnt_q <= gnt_d;
  end

  assign gnt_n = ~gnt_q;
endmodule

// File: rtl/rr2_bus_arbiter_chk.sv
module rr2_bus_arbiter_chk #(
  parameter int N_REQ    = 8,
  parameter int HOME_IDX = 0
) (
  input logic             clk,
  input logic             rst,
  input logic             arb_off,
  input logic             bus_idle,
  input logic [N_REQ-1:0] req_n,
  input logic [N_REQ-1:0] lo_mask,
  input logic [N_REQ-1:0] gnt_n
);
  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  AST_GNT_ONEHOT0: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~gnt_n)); // R4

  AST_OFF_IDLE: assert property (@(posedge clk) disable iff (rst)
    arb_off |=> (&gnt_n)); // R6

  AST_PARK_HOME: assert property (@(posedge clk) disable iff (rst)
    (!arb_off && (&req_n)) |=> !gnt_n[HOME_IDX]); // R7

  AST_GNT_TO_REQ: assert property (@(posedge clk) disable iff (rst)
    (!arb_off && !(&req_n)) |=> |(~gnt_n & ~$past(req_n))); // R1

  AST_HOLD_NO_START: assert property (@(posedge clk) disable iff (rst)
    (armed && !bus_idle && !arb_off && $stable(arb_off) && $stable(req_n) && $stable(lo_mask))
      |=> $stable(gnt_n)); // R9
endmodule

bind rr2_bus_arbiter rr2_bus_arbiter_chk #(.N_REQ(N_REQ), .HOME_IDX(HOME_IDX)) chk_i (
  .clk(clk), .rst(rst), .arb_off(arb_off), .bus_idle(bus_idle),
  .req_n(req_n), .lo_mask(lo_mask), .gnt_n(gnt_n)
);

// File: tb/rr2_bus_arbiter_tb.sv
module rr2_bus_arbiter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int HOME = 0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic arb_off = 1'b0;
  logic bus_idle = 1'b0;
  logic [N-1:0] req_n = '1;
  logic [N-1:0] lo_mask = '0;
  logic [N-1:0] gnt_n;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference state, following the requirement rules
  logic [N-1:0] m_gnt;
  int m_hi, m_lo;

  always #(CLK_PERIOD/2) clk = ~clk;

  rr2_bus_arbiter #(.N_REQ(N), .HOME_IDX(HOME)) dut_i (
    .clk(clk), .rst(rst), .arb_off(arb_off), .bus_idle(bus_idle),
    .req_n(req_n), .lo_mask(lo_mask), .gnt_n(gnt_n)
  );

  task automatic check(input bit ok, input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: gnt_n actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; req_n = '1; bus_idle = 1'b0; arb_off = 1'b0;
    repeat (2) @(negedge clk);
    check(gnt_n == '1, "R10 grants idle in reset", gnt_n, '1);
    rst = 1'b0;
    m_gnt = '0; m_hi = 0; m_lo = 0;
  endtask

  // one cycle: drive at negedge, predict the next rising edge, read at next negedge
  task automatic step(input logic [N-1:0] r, input logic [N-1:0] m, input bit bi,
                      input bit off, input string tag);
    logic [N-1:0] exp;
    int nh, nl, g;
    bit st, hf, lf;
    req_n = ~r; lo_mask = m; bus_idle = bi; arb_off = off;
    st = bi && ((m_gnt & r) != '0);
    g = 0;
    for (int i = 0; i < N; i++) if (m_gnt[i]) g = i;
    nh = m_hi; nl = m_lo;
    if (st) begin
      if (m[g]) begin nh = 0; nl = (g + 1) % N; end
      else nh = g + 1;
    end
    exp = '0; hf = 0;
    for (int k = 0; k <= N; k++) begin
      int s;
      s = (nh + k) % (N + 1);
      if (!hf) begin
        if (s == N) begin
          if ((r & m) != '0) begin
            hf = 1; lf = 0;
            for (int j = 0; j < N; j++) begin
              int t;
              t = (nl + j) % N;
              if (!lf && r[t] && m[t]) begin exp[t] = 1'b1; lf = 1; end
            end
          end
        end else if (r[s] && !m[s]) begin
          exp[s] = 1'b1; hf = 1;
        end
      end
    end
    if (off) exp = '0;
    else if (r == '0) exp = N'(1) << HOME;
    @(posedge clk);
    m_gnt = exp; m_hi = nh; m_lo = nl;
    @(negedge clk);
    check(gnt_n == ~exp, tag, gnt_n, ~exp);
    check($countones(~gnt_n) <= 1, "R4 at most one grant", gnt_n, ~exp);
  endtask

  initial begin
    int seq_a[7];
    int seq_b[4];
    seq_a = '{0, 1, 2, 0, 1, 3, 0};
    seq_b = '{0, 1, 0, 1};

    do_reset();
    // R10 / R7: no requests parks on home after reset
    step('0, '0, 1'b0, 1'b0, "R7 park on home");
    check(gnt_n == ~(N'(1) << HOME), "R7 park literal", gnt_n, ~(N'(1) << HOME));

    // R11 fairness sequence
    do_reset();
    for (int i = 0; i < 7; i++) begin
      step(4'b1111, 4'b1100, 1'b1, 1'b0, "R11 rotation model");
      check(gnt_n == ~(N'(1) << seq_a[i]), "R11 literal sequence", gnt_n, ~(N'(1) << seq_a[i]));
    end

    // R8 low place skipped when no low master requests
    do_reset();
    for (int i = 0; i < 4; i++) begin
      step(4'b0011, 4'b1100, 1'b1, 1'b0, "R8 skip model");
      check(gnt_n == ~(N'(1) << seq_b[i]), "R8 literal skip", gnt_n, ~(N'(1) << seq_b[i]));
    end

    // R6 disable: no grant, rotation frozen
    do_reset();
    step(4'b1111, 4'b0000, 1'b1, 1'b0, "R3 first grant");
    step(4'b1111, 4'b0000, 1'b1, 1'b1, "R6 off grants idle");
    check(gnt_n == '1, "R6 literal idle", gnt_n, '1);
    for (int i = 0; i < 3; i++) step(4'b1111, 4'b0000, 1'b1, 1'b1, "R6 off held");
    step(4'b1111, 4'b0000, 1'b1, 1'b0, "R6 rotation held while off");

    // R9 no start without bus_idle: grant holds
    step(4'b1111, 4'b0000, 1'b0, 1'b0, "R9 no start holds");
    step(4'b1111, 4'b0000, 1'b0, 1'b0, "R9 no start holds again");

    // R5 low rotation only
    do_reset();
    for (int i = 0; i < 6; i++) step(4'b1111, 4'b1111, 1'b1, 1'b0, "R5 low rotation");

    // R1 R2 R3 sweep over every mask and request pattern
    do_reset();
    for (int m = 0; m < 16; m++)
      for (int r = 0; r < 16; r++) begin
        step(N'(r), N'(m), 1'b1, 1'b0, "R1 R2 R3 sweep start");
        step(N'(r), N'(m), ((m + r) % 3) != 0, 1'b0, "R2 R3 R5 sweep mixed");
      end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule